// File: doc/BRIEF.md
# Receive Link Synchronization State Machine

This block decides whether a receive link is synchronized. Each cycle an upstream status encoder may present one classified word, marked by a valid strobe. The class says whether the word was an idle, a carrier extend, ordinary data, an error-propagation code, an invalid code, or a loss-of-signal report. From that stream the block holds a two-state machine and drives a single link-up indication. It also exposes the current state on a debug pin.

Out of reset the machine sits in an acquisition state. It leaves acquisition in two ways. A run of consecutive idle or extend words of a set length brings the link up. So does any single data or error-propagation word, with no wait.

Once synchronized, the link drops back to acquisition in two cases. One is a valid loss-of-signal word. The other is an unbroken run of invalid-code words. Both run lengths are parameters: `ACQ_RUN` (default 3) and `ERR_LIMIT` (default 4).

Top module: `lsync_fsm`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the machine is in acquisition, with `link_up` = 0 and `state_dbg` = 0.
- R2: In acquisition, `ACQ_RUN` consecutive valid words of class idle (code 0) or extend (code 1), in any mix, raise `link_up` at the clock edge that accepts the last of them.
- R3: In acquisition, one valid word of class data (code 2) or error propagation (code 3) raises `link_up` at the edge that accepts it.
- R4: `state_dbg` is 0 in acquisition and 1 when synchronized, and `link_up` is high exactly when `state_dbg` is 1.
- R5: In acquisition, a valid word of class invalid (code 4) or loss of signal (code 5) restarts the idle/extend run from zero.
- R6: When synchronized, a valid loss-of-signal word (code 5) returns the machine to acquisition at the edge that accepts it.
- R7: When synchronized, `ERR_LIMIT` valid invalid-code words with no other valid word between them return the machine to acquisition. Any valid idle, extend, data or error-propagation word clears that count.
- R8: A cycle with `word_vld` low leaves the state and both run counts unchanged, whatever `word_cls` carries.
- R9: Class codes 6 and 7 are handled exactly as invalid (code 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | A classified word is present this cycle |
| word_cls | input | 3 | Word class: 0 idle, 1 extend, 2 data, 3 error propagation, 4 invalid, 5 loss of signal, 6-7 treated as invalid |
| link_up | output | 1 | High while synchronized |
| state_dbg | output | 1 | State encoding: 0 acquisition, 1 synchronized |

## Verification
The bench builds the block with its defaults, `ACQ_RUN` = 3 and `ERR_LIMIT` = 4. With these values every threshold is crossed within a handful of words. That lets directed sequences cover several cases: a run cut one word short, an error run broken one word before the limit, and gaps with the strobe low inside both runs. A long random stream of classes then follows, and its transitions are compared on every edge with a behavioural model.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic [2:0] {
    WC_IDLE    = 3'd0,
    WC_EXTEND  = 3'd1,
    WC_DATA    = 3'd2,
    WC_ERRPROP = 3'd3,
    WC_INVALID = 3'd4,
    WC_LOS     = 3'd5
  } word_cls_e;

  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_SYNC = 1'b1
  } lsync_state_e;

  // idle or carrier extend: counts toward the acquisition run
  function automatic logic cls_is_run(input logic [2:0] c);
    return (c == WC_IDLE) || (c == WC_EXTEND);
  endfunction

  // data or error propagation: enters sync at once
  function automatic logic cls_is_direct(input logic [2:0] c);
    return (c == WC_DATA) || (c == WC_ERRPROP);
  endfunction

  // invalid code, including the two unassigned codes
  function automatic logic cls_is_bad(input logic [2:0] c);
    return (c == WC_INVALID) || (c > WC_LOS);
  endfunction

  function automatic logic cls_is_los(input logic [2:0] c);
    return c == WC_LOS;
  endfunction

endpackage

// File: rtl/lsync_classify.sv
module lsync_classify
  import lsync_pkg::*;
(
  input  logic [2:0] cls,
  output logic       is_run,
  output logic       is_direct,
  output logic       is_bad,
  output logic       is_los
);

  always_comb begin
    is_run    = cls_is_run(cls);
    is_direct = cls_is_direct(cls);
    is_bad    = cls_is_bad(cls);
    is_los    = cls_is_los(cls);
  end

endmodule

// File: rtl/lsync_run_counter.sv
module lsync_run_counter #(
  parameter int LIMIT = 3,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          last
);

  localparam logic [CW-1:0] LastVal = CW'(LIMIT - 1);

  // the increment that would reach LIMIT: the run is complete
  assign last = inc && (cnt == LastVal);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || last) cnt <= '0;
    else if (inc)         cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/lsync_fsm.sv
module lsync_fsm
  import lsync_pkg::*;
#(
  parameter int ACQ_RUN   = 3,
  parameter int ERR_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_vld,
  input  logic [2:0] word_cls,
  output logic       link_up,
  output logic       state_dbg
);

  localparam int RunW = $clog2(ACQ_RUN + 1);
  localparam int ErrW = $clog2(ERR_LIMIT + 1);

  lsync_state_e state_q;
  logic is_run, is_direct, is_bad, is_los;
  logic in_acq;
  logic run_inc, run_clr, run_hit;
  logic err_inc, err_clr, err_hit;
  logic go_sync, go_acq;
  logic [RunW-1:0] run_cnt;
  logic [ErrW-1:0] err_cnt;

  lsync_classify u_cls (
    .cls       (word_cls),
    .is_run    (is_run),
    .is_direct (is_direct),
    .is_bad    (is_bad),
    .is_los    (is_los)
  );

  assign in_acq = (state_q == ST_ACQ);

  // acquisition run: idle/extend words while searching
  assign run_inc = word_vld && in_acq && is_run;
  assign run_clr = !in_acq || (word_vld && !is_run);

  lsync_run_counter #(.LIMIT(ACQ_RUN)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (run_inc),
    .clr   (run_clr),
    .cnt   (run_cnt),
    .last  (run_hit)
  );

  // error run: invalid words while synchronized
  assign err_inc = word_vld && !in_acq && is_bad;
  assign err_clr = in_acq || (word_vld && !is_bad);

  lsync_run_counter #(.LIMIT(ERR_LIMIT)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .clr   (err_clr),
    .cnt   (err_cnt),
    .last  (err_hit)
  );

  assign go_sync = in_acq && word_vld && (is_direct || run_hit);
  assign go_acq  = !in_acq && word_vld && (is_los || err_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= ST_ACQ;
    else if (go_sync) state_q <= ST_SYNC;
    else if (go_acq)  state_q <= ST_ACQ;
  end

  assign link_up   = (state_q == ST_SYNC);
  assign state_dbg = state_q;

endmodule

// File: rtl/lsync_chk.sv
module lsync_chk
  import lsync_pkg::*;
#(
  parameter int ACQ_RUN   = 3,
  parameter int ERR_LIMIT = 4,
  localparam int RunW     = $clog2(ACQ_RUN + 1),
  localparam int ErrW     = $clog2(ERR_LIMIT + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            word_vld,
  input logic [2:0]      word_cls,
  input logic            link_up,
  input logic            state_dbg,
  input logic [RunW-1:0] run_cnt,
  input logic [ErrW-1:0] err_cnt
);

  AST_DIRECT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && word_vld && (word_cls == WC_DATA || word_cls == WC_ERRPROP)) |=> link_up); // R3

  AST_SHORT_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ACQ_RUN > 1 && !link_up && run_cnt == '0 && word_vld && word_cls == WC_IDLE) |=> !link_up); // R2

  AST_LOS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && word_vld && word_cls == WC_LOS) |=> !link_up); // R6

  AST_DATA_KEEPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && word_vld && word_cls == WC_DATA) |=> (link_up && err_cnt == '0)); // R7

  AST_IDLE_CYCLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> ($stable(link_up) && $stable(run_cnt) && $stable(err_cnt))); // R8

  AST_ACQ_NO_ERRCNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg == 1'b0) |-> (err_cnt == '0)); // R7

  AST_SYNC_NO_RUNCNT: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (run_cnt == '0)); // R5

  AST_COUNTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_cnt) < ACQ_RUN) && (int'(err_cnt) < ERR_LIMIT)); // R2

endmodule

bind lsync_fsm lsync_chk #(.ACQ_RUN(ACQ_RUN), .ERR_LIMIT(ERR_LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_vld  (word_vld),
  .word_cls  (word_cls),
  .link_up   (link_up),
  .state_dbg (state_dbg),
  .run_cnt   (run_cnt),
  .err_cnt   (err_cnt)
);

// File: tb/tb_lsync_fsm.sv
module tb_lsync_fsm;

  localparam int CLK_PERIOD = 10;
  localparam int ACQ_RUN    = 3;
  localparam int ERR_LIMIT  = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_vld = 1'b0;
  logic [2:0] word_cls = 3'd0;
  logic       link_up;
  logic       state_dbg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  int m_sync = 0;
  int m_run  = 0;
  int m_err  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsync_fsm #(.ACQ_RUN(ACQ_RUN), .ERR_LIMIT(ERR_LIMIT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .word_cls  (word_cls),
    .link_up   (link_up),
    .state_dbg (state_dbg)
  );

  task automatic model_step(input bit v, input int c);
    bit bad;
    if (!v) return;
    bad = (c == 4) || (c >= 6);
    if (m_sync == 0) begin
      m_err = 0;
      if (c == 0 || c == 1) begin
        m_run = m_run + 1;
        if (m_run >= ACQ_RUN) begin m_sync = 1; m_run = 0; end
      end else if (c == 2 || c == 3) begin
        m_sync = 1; m_run = 0;
      end else begin
        m_run = 0;
      end
    end else begin
      if (c == 5) begin
        m_sync = 0; m_err = 0;
      end else if (bad) begin
        m_err = m_err + 1;
        if (m_err >= ERR_LIMIT) begin m_sync = 0; m_err = 0; end
      end else begin
        m_err = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    checks++;
    if (link_up !== m_sync[0] || state_dbg !== m_sync[0]) begin
      errors++;
      $display("FAIL %s: link_up=%b state_dbg=%b expected %0d (t=%0t)",
               req, link_up, state_dbg, m_sync, $time);
    end
  endtask

  task automatic step(input bit v, input int c, input string req);
    @(negedge clk);
    word_vld = v;
    word_cls = 3'(c);
    @(posedge clk);
    model_step(v, c);
    #1;
    compare(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 compare("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after reset");

    // R2: three idles, not earlier
    step(1, 0, "R2 idle 1");
    step(1, 0, "R2 idle 2");
    step(1, 0, "R2 idle 3 enters sync");

    // R7: error run broken one short, then completed
    step(1, 4, "R7 inv 1");
    step(1, 4, "R7 inv 2");
    step(1, 4, "R7 inv 3");
    step(1, 2, "R7 data clears");
    step(1, 4, "R7 inv 1b");
    step(1, 4, "R7 inv 2b");
    step(1, 4, "R7 inv 3b");
    step(1, 4, "R7 inv 4 drops");

    // R5: invalid restarts the run; R2 mixed idle/extend
    step(1, 0, "R5 idle");
    step(1, 1, "R5 extend");
    step(1, 4, "R5 invalid restart");
    step(1, 0, "R5 idle a");
    step(1, 1, "R5 extend b");
    step(1, 1, "R2 extend completes run");

    // R6: LOS drops sync
    step(1, 5, "R6 los drops");

    // R5 LOS restart, R8 gaps inside run
    step(1, 0, "R5 idle");
    step(1, 0, "R5 idle");
    step(1, 5, "R5 los restart");
    step(1, 1, "R8 ext 1");
    step(0, 2, "R8 gap data ignored");
    step(1, 0, "R8 idle 2");
    step(0, 0, "R8 gap idle ignored");
    step(0, 3, "R8 gap errprop ignored");
    step(1, 0, "R8 idle 3 enters sync");

    // R9: codes 6/7 count as invalid; R8 gaps in the error run
    step(1, 6, "R9 code6");
    step(0, 5, "R8 gap los ignored");
    step(1, 7, "R9 code7");
    step(1, 4, "R9 inv");
    step(0, 4, "R8 gap inv ignored");
    step(1, 7, "R9 code7 drops");

    // R3: direct entry with data and with error propagation
    step(1, 2, "R3 data enters sync");
    step(1, 5, "R6 los");
    step(1, 3, "R3 errprop enters sync");
    step(1, 0, "R4 idle in sync");
    step(1, 1, "R4 extend in sync");

    // R1: reset mid-sync returns to acquisition
    @(negedge clk); rst_n = 1'b0; word_vld = 1'b1; word_cls = 3'd2;
    @(posedge clk); m_sync = 0; m_run = 0; m_err = 0;
    #1 compare("R1 reset from sync");
    @(negedge clk); rst_n = 1'b1; word_vld = 1'b0;
    @(posedge clk); #1 compare("R1 after second reset");

    // R4: random stream compared each edge
    for (int i = 0; i < 400; i++) begin
      int c;
      int r;
      r = $urandom_range(0, 9);
      c = (r < 4) ? 0 : (r < 5) ? 1 : (r < 8) ? 4 : $urandom_range(0, 7);
      step($urandom_range(0, 4) != 0, c, "R4 random");
    end

    finish_run();
  end

endmodule